// File: doc/BRIEF.md
# Automatic Turbo Clock Switcher

This block picks which of two clock enables drives the CPU: a fast turbo enable (around 7 MHz) or the standard 3.58 MHz enable. Both enables are single-cycle pulses on one master clock. Whenever the CPU makes an I/O access to the video display processor's port group, the block drops the CPU to the standard speed. Slow timing gives the video chip time to finish its memory transfer. Any other bus access leaves the speed alone.

After the last video access, a hold timer keeps the CPU slow for a programmable number of standard-speed ticks. The timer counts only standard-speed enable pulses, so the hold time in microseconds does not depend on which speed is running. Every new video access restarts the hold period. The selection changes only in a master-clock cycle where neither enable is pulsing, so the CPU never sees a shortened clock phase.

Out of reset the CPU runs slow for one full hold period and then goes to turbo. A status pin reports which speed is in use. All pins are plain control and status signals; the block has no data stream and no handshake.

Top module: `turbo_clk_switch`

## Requirements
- R1: While reset is held, and after reset is released, turbo_active is 0 and cpu_ce follows slow_ce. This continues until hold_cycles slow_ce pulses have passed; turbo then starts at the next switch point.
- R2: A cycle with io_strobe=1 and io_addr in 0x98..0x9B (default PORT_BASE=0x98, PORT_COUNT=4) counts as a video access. It forces slow selection at the next switch point. While a hold period is running, the block never returns to turbo.
- R3: A strobe to an address outside the port group does not change the selected speed. Neither does a port-group address without io_strobe.
- R4: The hold timer counts only slow_ce pulses. The hold ends after hold_cycles slow_ce pulses following the last video access.
- R5: A video access during a running hold period reloads the timer with hold_cycles.
- R6: The selected speed changes only at a rising clock edge where fast_ce and slow_ce are both 0.
- R7: On every cycle, cpu_ce equals the enable of the selected source. cpu_ce never pulses when both source enables are 0.
- R8: turbo_active is 1 exactly when the fast source is selected.
- R9: With hold_cycles=0, the slow speed is kept only through switch points that fall inside the access cycle. The block is back in turbo at the next switch point after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_ce | input | 1 | Turbo clock-enable pulse |
| slow_ce | input | 1 | Standard 3.58 MHz clock-enable pulse |
| io_strobe | input | 1 | One-cycle pulse marking a CPU I/O access |
| io_addr | input | ADDR_W | I/O port address of the access |
| hold_cycles | input | HOLD_W | Hold length in slow_ce pulses |
| cpu_ce | output | 1 | Clock enable delivered to the CPU |
| turbo_active | output | 1 | 1 while the turbo source is selected |

## Verification
The assertions assume three things about the inputs. First, fast_ce and slow_ce are single-cycle pulses whose phases regularly leave cycles where both are 0; without such cycles the speed could never change. Second, io_strobe is high for exactly one cycle per access. Third, hold_cycles changes only while no hold period is running. The stimulus generates both enables from one free-running counter: fast_ce is high when the count is 0 mod 4 and slow_ce when it is 1 mod 8, so every 8-cycle frame has five switch cycles. Accesses are issued as one-cycle pulses, and hold_cycles is changed only after the block has gone back to turbo.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  typedef enum logic {
    SPD_SLOW  = 1'b0,
    SPD_TURBO = 1'b1
  } speed_e;
endpackage

// File: rtl/tcs_port_match.sv
module tcs_port_match #(
  parameter int ADDR_W     = 8,
  parameter int PORT_BASE  = 'h98,
  parameter int PORT_COUNT = 4
) (
  input  logic              io_strobe,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              video_hit
);
  logic [PORT_COUNT-1:0] eq;

  // one comparator per port in the video group
  for (genvar i = 0; i < PORT_COUNT; i++) begin : g_cmp
    assign eq[i] = (io_addr == ADDR_W'(PORT_BASE + i));
  end

  assign video_hit = io_strobe && (|eq);
endmodule

// File: rtl/tcs_hold_timer.sv
module tcs_hold_timer #(
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              retrig,
  input  logic [HOLD_W-1:0] hold_len,
  output logic              hold_busy
);
  logic              armed;
  logic [HOLD_W-1:0] remain;

  // slow is wanted before the first load, while counting, and on an access
  assign hold_busy = !armed || (remain != '0) || retrig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      remain <= '0;
    end else if (!armed || retrig) begin
      armed  <= 1'b1;
      remain <= hold_len;
    end else if (slow_tick && (remain != '0)) begin
      remain <= remain - 1'b1;
    end
  end

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    retrig |=> (remain == $past(hold_len)));

  p_no_growth_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !retrig) |=> (remain <= $past(remain)));

  p_idle_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !retrig && !slow_tick) |=> $stable(remain));
endmodule

// File: rtl/tcs_ce_select.sv
module tcs_ce_select
  import tcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fast_ce,
  input  logic slow_ce,
  input  logic want_slow,
  output logic cpu_ce,
  output logic turbo_on
);
  speed_e cur;
  logic   window;

  assign window = !fast_ce && !slow_ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur <= SPD_SLOW;
    else if (window) cur <= want_slow ? SPD_SLOW : SPD_TURBO;
  end

  assign cpu_ce   = (cur == SPD_SLOW) ? slow_ce : fast_ce;
  assign turbo_on = (cur == SPD_TURBO);

  p_switch_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur != $past(cur)) |-> (!$past(fast_ce) && !$past(slow_ce)));

  p_no_stray_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ce |-> (fast_ce || slow_ce));
endmodule

// File: rtl/turbo_clk_switch.sv
module turbo_clk_switch #(
  parameter int ADDR_W     = 8,
  parameter int PORT_BASE  = 'h98,
  parameter int PORT_COUNT = 4,
  parameter int HOLD_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_ce,
  input  logic              slow_ce,
  input  logic              io_strobe,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [HOLD_W-1:0] hold_cycles,
  output logic              cpu_ce,
  output logic              turbo_active
);
  logic video_hit;
  logic busy;

  tcs_port_match #(
    .ADDR_W(ADDR_W), .PORT_BASE(PORT_BASE), .PORT_COUNT(PORT_COUNT)
  ) u_match (
    .io_strobe(io_strobe), .io_addr(io_addr), .video_hit(video_hit)
  );

  tcs_hold_timer #(.HOLD_W(HOLD_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_ce), .retrig(video_hit),
    .hold_len(hold_cycles), .hold_busy(busy)
  );

  tcs_ce_select u_sel (
    .clk(clk), .rst_n(rst_n), .fast_ce(fast_ce), .slow_ce(slow_ce),
    .want_slow(busy), .cpu_ce(cpu_ce), .turbo_on(turbo_active)
  );

  p_busy_holds_slow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !turbo_active) |=> !turbo_active);

  p_turbo_drives_fast_r8: assert property (@(posedge clk) disable iff (!rst_n)
    turbo_active |-> (cpu_ce == fast_ce));
endmodule

// File: tb/sim_turbo_clk_switch.sv
module sim_turbo_clk_switch;
  localparam int PERIOD = 10;
  localparam int HW     = 16;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          fast_ce = 0, slow_ce = 0;
  logic          io_strobe = 0;
  logic [7:0]    io_addr = 0;
  logic [HW-1:0] hold_cycles = 5;
  logic          cpu_ce, turbo_active;

  int total = 0, bad = 0;
  bit done = 0;
  string cur_req = "R1";

  turbo_clk_switch u0 (
    .clk(clk), .rst_n(rst_n), .fast_ce(fast_ce), .slow_ce(slow_ce),
    .io_strobe(io_strobe), .io_addr(io_addr), .hold_cycles(hold_cycles),
    .cpu_ce(cpu_ce), .turbo_active(turbo_active)
  );

  always #(PERIOD/2) clk = ~clk;

  // enable pulse generator: fast at 0 mod 4, slow at 1 mod 8
  int unsigned phase = 0;
  always @(negedge clk) begin
    phase   <= phase + 1;
    fast_ce <= ((phase + 1) % 4) == 0;
    slow_ce <= ((phase + 1) % 8) == 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model built from the requirements; pushes expectations
  typedef struct packed { logic ce; logic tb; } exp_t;
  exp_t q[$];
  bit   m_armed = 0, m_slow = 1;
  int   m_rem = 0;
  always @(posedge clk) begin
    bit hit, want;
    hit  = io_strobe && io_addr >= 8'h98 && io_addr <= 8'h9B;
    if (!rst_n) begin
      m_armed = 0; m_rem = 0; m_slow = 1;
    end else begin
      want = !m_armed || m_rem != 0 || hit;
      if (!fast_ce && !slow_ce) m_slow = want;
      if (!m_armed || hit) begin m_armed = 1; m_rem = int'(hold_cycles); end
      else if (slow_ce && m_rem != 0) m_rem--;
    end
    q.push_back('{ce: (m_slow ? slow_ce : fast_ce), tb: !m_slow});
  end

  // monitor: pops expectations and compares away from the edge
  logic prev_tb = 0;
  bit   have_prev = 0;
  always @(posedge clk) begin
    exp_t e;
    #(PERIOD/4);
    if (q.size() != 0 && !done) begin
      e = q.pop_front();
      chk(cpu_ce === e.ce, {cur_req, "/R7 cpu_ce"}, int'(cpu_ce), int'(e.ce));
      chk(turbo_active === e.tb, {cur_req, "/R8 turbo_active"}, int'(turbo_active), int'(e.tb));
      if (have_prev && rst_n && turbo_active !== prev_tb)
        chk(!fast_ce && !slow_ce, "R6 switch outside window", int'({fast_ce, slow_ce}), 0);
      prev_tb   = turbo_active;
      have_prev = 1;
    end
  end

  task automatic access(input logic [7:0] a, input bit strobe);
    @(negedge clk);
    io_strobe = strobe; io_addr = a;
    @(negedge clk);
    io_strobe = 0; io_addr = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    cur_req = "R1";
    wait_cyc(4);
    chk(turbo_active == 0, "R1 in reset", int'(turbo_active), 0);
    rst_n = 1;
    wait_cyc(10);
    chk(turbo_active == 0, "R1 start slow", int'(turbo_active), 0);
    wait_cyc(50);
    chk(turbo_active == 1, "R1 turbo after first hold", int'(turbo_active), 1);

    cur_req = "R3";
    access(8'hA0, 1); access(8'h97, 1); access(8'h9C, 1); access(8'h98, 0);
    wait_cyc(10);
    chk(turbo_active == 1, "R3 non-video accesses ignored", int'(turbo_active), 1);

    cur_req = "R2";
    access(8'h98, 1);
    wait_cyc(10);
    chk(turbo_active == 0, "R2 video access goes slow", int'(turbo_active), 0);
    cur_req = "R4";
    wait_cyc(20);
    chk(turbo_active == 0, "R4 still holding", int'(turbo_active), 0);
    wait_cyc(30);
    chk(turbo_active == 1, "R4 turbo after hold", int'(turbo_active), 1);

    cur_req = "R5";
    access(8'h9B, 1);
    wait_cyc(25);
    access(8'h99, 1);
    wait_cyc(25);
    chk(turbo_active == 0, "R5 retrigger extends hold", int'(turbo_active), 0);
    wait_cyc(40);
    chk(turbo_active == 1, "R5 turbo after extended hold", int'(turbo_active), 1);

    cur_req = "R9";
    hold_cycles = 0;
    access(8'h9A, 1);
    wait_cyc(12);
    chk(turbo_active == 1, "R9 zero hold returns to turbo", int'(turbo_active), 1);

    cur_req = "R4";
    hold_cycles = 3;
    access(8'h98, 1);
    wait_cyc(8);
    chk(turbo_active == 0, "R4 short hold slow", int'(turbo_active), 0);
    wait_cyc(40);
    chk(turbo_active == 1, "R4 short hold ends", int'(turbo_active), 1);

    wait_cyc(4);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end
endmodule